// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches up to 32 power partitions on and off and owns the isolation clamp of each one. Software reaches it through a plain 32-bit register bus: an address, a write enable, write data and a combinational read-data return. A power change is requested by writing a partition number together with a start flag. The block then inverts that partition's power enable after a fixed number of clock cycles, which stands in for the latency of a real power switch. While the toggle is in flight the start flag reads back as 1, and it clears itself when the toggle completes.

After a partition is powered, software releases its isolation clamp by writing a one-hot mask to a clamp-release command register. Each accepted bit stays set until a single shared release engine has served it, lowest partition first, after its own fixed latency. A release aimed at an unpowered partition is refused and raises a sticky error output. A partition that powers down has its clamp re-applied on that same edge, so it comes back up isolated. Both latencies are parameters, and elaboration confirms that the worst case fits inside a 100 microsecond polling window.

Register offsets are fixed, because software decodes them:
- 0x02C reads the clamp state.
- 0x030 is the toggle register. Bit 8 is the start flag and bits 4:0 hold the partition number.
- 0x034 is the clamp-release command.
- 0x038 reads the power state.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset every power enable is 0, every clamp is 1, the start flag (0x030 bit 8) reads 0, the command register 0x034 reads 0 and `clamp_err` is 0.
- R2: A write to 0x030 with bit 8 = 1 and partition number p = bits 4:0, made while idle, makes bit 8 read 1 for exactly TOGGLE_CYCLES cycles after the write edge. On the edge that clears it, `pwr_en[p]` changes. During the toggle, 0x030 reads 0x100 | p.
- R3: A toggle inverts the selected partition's power state rather than setting it, so two toggles of one partition leave it as it was.
- R4: A toggle write is ignored, leaving power and the in-flight partition unchanged, if bit 8 is 0, if p >= NUM_PART, or if a toggle is already in flight.
- R5: Bit n of 0x038 equals `pwr_en[n]` and bit n of 0x02C equals `clamp[n]`. Bits at or above NUM_PART read 0, and unmapped offsets read 0.
- R6: A write of bit n to 0x034 for a powered partition, with no other release pending, sets bit n of 0x034. Both that bit and `clamp[n]` clear on the edge CLAMP_CYCLES+1 cycles after the write edge.
- R7: Pending releases are served one at a time, lowest partition first. The k-th pending partition in ascending order (k from 1) is released k*(CLAMP_CYCLES+1) cycles after the write edge.
- R8: A release aimed at an unpowered partition leaves its clamp at 1 and its bit of 0x034 at 0, and sets `clamp_err`. `clamp_err` then stays 1 until reset.
- R9: On the edge where a partition powers off, its clamp becomes 1 and any pending release for it is dropped.
- R10: A release write is judged against the power state before its edge. If it coincides with power-on completion it is refused (R8). If it coincides with power-off completion it is dropped without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwr_en | output | NUM_PART | Power enable per partition |
| clamp | output | NUM_PART | Isolation clamp per partition, 1 = clamped |
| clamp_err | output | 1 | Sticky flag: release requested on an unpowered partition |

## Verification
The toggle engine's completion and a clamp-release write can land on the same clock edge for the same partition. This is the case where the decision order matters. The bench provokes it by counting cycles from the toggle write and placing the release write exactly on the completion edge, once with the partition powering up and once with it powering down. For the power-up case it expects a refusal with `clamp_err` set. For the power-down case it expects a silently dropped command with the clamp held and no error. The ordered service of several pending releases is also swept cycle by cycle against release times computed in the bench from each partition's rank.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   // Byte offsets decoded by software
   localparam int unsigned OFS_CLAMP_STAT = 32'h02C;
   localparam int unsigned OFS_TOGGLE     = 32'h030;
   localparam int unsigned OFS_CLAMP_CMD  = 32'h034;
   localparam int unsigned OFS_PWR_STAT   = 32'h038;
   // Toggle register fields
   localparam int unsigned TOG_START_BIT  = 8;
   localparam int unsigned TOG_ID_W       = 5;
   localparam int unsigned MAX_PART       = 32;
   localparam int unsigned POLL_WINDOW_US = 100;
endpackage

// File: rtl/pgc_regif.sv
module pgc_regif
   import pgc_pkg::*;
#(
   parameter int unsigned NUM_PART = 32,
   parameter int unsigned ADDR_W   = 12
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [31:0]         wdata,
   input  logic                tog_busy,
   input  logic [TOG_ID_W-1:0] tog_id,
   input  logic [NUM_PART-1:0] pwr,
   input  logic [NUM_PART-1:0] clamp,
   input  logic [NUM_PART-1:0] pend,
   output logic                tog_req,
   output logic [TOG_ID_W-1:0] tog_req_id,
   output logic                rel_req,
   output logic [NUM_PART-1:0] rel_mask,
   output logic [31:0]         rdata
);
   localparam logic [ADDR_W-1:0] A_CSTAT = ADDR_W'(OFS_CLAMP_STAT);
   localparam logic [ADDR_W-1:0] A_TOG   = ADDR_W'(OFS_TOGGLE);
   localparam logic [ADDR_W-1:0] A_CCMD  = ADDR_W'(OFS_CLAMP_CMD);
   localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(OFS_PWR_STAT);
   localparam logic [5:0]        PART_LIM = 6'(NUM_PART);

   logic id_ok;

   assign tog_req_id = wdata[TOG_ID_W-1:0];
   assign id_ok      = {1'b0, tog_req_id} < PART_LIM;
   assign tog_req    = we && (addr == A_TOG) && wdata[TOG_START_BIT] && id_ok;
   assign rel_req    = we && (addr == A_CCMD);
   assign rel_mask   = wdata[NUM_PART-1:0];

   always_comb begin
      rdata = '0;
      case (addr)
         A_CSTAT: rdata[NUM_PART-1:0] = clamp;
         A_PSTAT: rdata[NUM_PART-1:0] = pwr;
         A_CCMD:  rdata[NUM_PART-1:0] = pend;
         A_TOG: begin
            rdata[TOG_START_BIT]  = tog_busy;
            rdata[TOG_ID_W-1:0]   = tog_id;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/pgc_toggle_eng.sv
module pgc_toggle_eng
   import pgc_pkg::*;
#(
   parameter int unsigned NUM_PART = 32,
   parameter int unsigned LAT      = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req,
   input  logic [TOG_ID_W-1:0] req_id,
   output logic                busy,
   output logic [TOG_ID_W-1:0] id,
   output logic [NUM_PART-1:0] pwr,
   output logic [NUM_PART-1:0] off_now
);
   localparam int unsigned CW = $clog2(LAT + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

   logic [CW-1:0] cnt;
   logic          fin;

   assign fin = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
         id   <= '0;
      end else if (!busy) begin
         if (req) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
            id   <= req_id;
         end
      end else if (fin) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_PART; g++) begin : g_part
      logic hit;
      assign hit        = fin && (id == TOG_ID_W'(g));
      assign off_now[g] = hit && pwr[g];
      always_ff @(posedge clk) begin
         if (rst)      pwr[g] <= 1'b0;
         else if (hit) pwr[g] <= ~pwr[g];
      end
   end
endmodule

// File: rtl/pgc_clamp_eng.sv
module pgc_clamp_eng #(
   parameter int unsigned NUM_PART = 32,
   parameter int unsigned LAT      = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req,
   input  logic [NUM_PART-1:0] mask,
   input  logic [NUM_PART-1:0] pwr,
   input  logic [NUM_PART-1:0] off_now,
   output logic [NUM_PART-1:0] clamp,
   output logic [NUM_PART-1:0] pend,
   output logic                err
);
   localparam int unsigned CW    = $clog2(LAT + 1);
   localparam int unsigned IDX_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;
   localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

   logic              act;
   logic [IDX_W-1:0]  sel;
   logic [CW-1:0]     cnt;
   logic              cancel;
   logic [NUM_PART-1:0] avail;
   logic [IDX_W-1:0]  low_idx;
   logic [NUM_PART-1:0] rel;
   logic              reject;

   assign avail  = pend & ~off_now;
   assign cancel = act && off_now[sel];
   assign reject = req && ((mask & ~pwr) != '0);

   // lowest-index pick among pending partitions
   always_comb begin
      low_idx = '0;
      for (int i = NUM_PART - 1; i >= 0; i--) begin
         if (avail[i]) low_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act <= 1'b0;
         sel <= '0;
         cnt <= '0;
      end else if (act) begin
         if (cancel || cnt == '0) act <= 1'b0;
         else                     cnt <= cnt - 1'b1;
      end else if (avail != '0) begin
         act <= 1'b1;
         sel <= low_idx;
         cnt <= CNT_LOAD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         err <= 1'b0;
      else if (reject) err <= 1'b1;
   end

   for (genvar g = 0; g < NUM_PART; g++) begin : g_part
      logic accept;
      assign rel[g] = act && !cancel && (cnt == '0) && (sel == IDX_W'(g));
      assign accept = req && mask[g] && pwr[g];
      always_ff @(posedge clk) begin
         if (rst) begin
            clamp[g] <= 1'b1;
            pend[g]  <= 1'b0;
         end else if (off_now[g]) begin
            clamp[g] <= 1'b1;
            pend[g]  <= 1'b0;
         end else if (rel[g]) begin
            clamp[g] <= 1'b0;
            pend[g]  <= 1'b0;
         end else if (accept) begin
            pend[g]  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
   import pgc_pkg::*;
#(
   parameter int unsigned NUM_PART      = 32,
   parameter int unsigned ADDR_W        = 12,
   parameter int unsigned TOGGLE_CYCLES = 16,
   parameter int unsigned CLAMP_CYCLES  = 8,
   parameter int unsigned CLK_MHZ       = 125
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PART-1:0] pwr_en,
   output logic [NUM_PART-1:0] clamp,
   output logic                clamp_err
);
   localparam int unsigned WINDOW_CYC = POLL_WINDOW_US * CLK_MHZ;
   localparam int unsigned CLAMP_WORST = NUM_PART * (CLAMP_CYCLES + 1);

   if (NUM_PART < 1 || NUM_PART > MAX_PART) begin : g_bad_part
      $error("pgate_ctrl: NUM_PART must be 1..32");
   end
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
      $error("pgate_ctrl: ADDR_W must be 7..32");
   end
   if (TOGGLE_CYCLES < 1 || CLAMP_CYCLES < 1) begin : g_bad_lat
      $error("pgate_ctrl: latencies must be at least 1");
   end
   if (TOGGLE_CYCLES >= WINDOW_CYC || CLAMP_WORST >= WINDOW_CYC) begin : g_bad_window
      $error("pgate_ctrl: latency exceeds polling window");
   end

   logic                tog_req;
   logic [TOG_ID_W-1:0] tog_req_id;
   logic                tog_busy;
   logic [TOG_ID_W-1:0] tog_id;
   logic [NUM_PART-1:0] off_now;
   logic                rel_req;
   logic [NUM_PART-1:0] rel_mask;
   logic [NUM_PART-1:0] clr_pend;

   pgc_regif #(.NUM_PART(NUM_PART), .ADDR_W(ADDR_W)) u_regif (
      .addr       (bus_addr),
      .we         (bus_we),
      .wdata      (bus_wdata),
      .tog_busy   (tog_busy),
      .tog_id     (tog_id),
      .pwr        (pwr_en),
      .clamp      (clamp),
      .pend       (clr_pend),
      .tog_req    (tog_req),
      .tog_req_id (tog_req_id),
      .rel_req    (rel_req),
      .rel_mask   (rel_mask),
      .rdata      (bus_rdata)
   );

   pgc_toggle_eng #(.NUM_PART(NUM_PART), .LAT(TOGGLE_CYCLES)) u_toggle (
      .clk     (clk),
      .rst     (rst),
      .req     (tog_req),
      .req_id  (tog_req_id),
      .busy    (tog_busy),
      .id      (tog_id),
      .pwr     (pwr_en),
      .off_now (off_now)
   );

   pgc_clamp_eng #(.NUM_PART(NUM_PART), .LAT(CLAMP_CYCLES)) u_clamp (
      .clk     (clk),
      .rst     (rst),
      .req     (rel_req),
      .mask    (rel_mask),
      .pwr     (pwr_en),
      .off_now (off_now),
      .clamp   (clamp),
      .pend    (clr_pend),
      .err     (clamp_err)
   );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
   parameter int unsigned NUM_PART = 32
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_PART-1:0] pwr_en,
   input logic [NUM_PART-1:0] clamp,
   input logic                clamp_err,
   input logic                tog_busy,
   input logic [4:0]          tog_id,
   input logic [NUM_PART-1:0] pend
);
   // R2: power only changes on the edge that ends a toggle
   p_pwr_on_done_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(pwr_en) |-> ($past(tog_busy) && !tog_busy));

   // R3: a completed toggle flips exactly one partition
   p_single_flip_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(pwr_en) |-> ($countones(pwr_en ^ $past(pwr_en)) == 1));

   // R4: the in-flight partition cannot be replaced
   p_id_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (tog_busy && $past(tog_busy)) |-> $stable(tog_id));

   // R6: only powered partitions carry a pending release
   p_pend_powered_r6: assert property (@(posedge clk) disable iff (rst)
      ((pend & ~pwr_en) == '0));

   // R7: at most one clamp is released per cycle
   p_one_release_r7: assert property (@(posedge clk) disable iff (rst)
      ($countones($past(clamp) & ~clamp) <= 1));

   // R8: the error flag is sticky
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      $past(clamp_err) |-> clamp_err);

   // R9: an unpowered partition is always clamped
   p_off_clamped_r9: assert property (@(posedge clk) disable iff (rst)
      ((~pwr_en & ~clamp) == '0));
endmodule

bind pgate_ctrl pgc_checker #(.NUM_PART(NUM_PART)) u_pgc_checker (
   .clk       (clk),
   .rst       (rst),
   .pwr_en    (pwr_en),
   .clamp     (clamp),
   .clamp_err (clamp_err),
   .tog_busy  (tog_busy),
   .tog_id    (tog_id),
   .pend      (clr_pend)
);

// File: tb/pgate_ctrl_bench.sv
module pgate_ctrl_bench;
   localparam int NP = 6;
   localparam int TL = 3;
   localparam int CL = 2;
   localparam logic [11:0] A_CST = 12'h02C;
   localparam logic [11:0] A_TOG = 12'h030;
   localparam logic [11:0] A_CMD = 12'h034;
   localparam logic [11:0] A_PST = 12'h038;
   localparam logic [NP-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [11:0]   bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pwr_en;
   logic [NP-1:0] clamp;
   logic          clamp_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [NP-1:0] e_pwr;
   logic [NP-1:0] e_clamp;

   always #4 clk = ~clk;

   pgate_ctrl #(.NUM_PART(NP), .ADDR_W(12), .TOGGLE_CYCLES(TL),
                .CLAMP_CYCLES(CL), .CLK_MHZ(125)) u_pgate_ctrl (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
      .clamp(clamp), .clamp_err(clamp_err));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // full toggle of partition p with per-cycle checks (R2, R3, R9)
   task automatic do_toggle(input int p);
      logic [31:0] v;
      logic [NP-1:0] nxt_pwr, nxt_clamp;
      nxt_pwr = e_pwr ^ NP'(1 << p);
      nxt_clamp = nxt_pwr[p] ? e_clamp : (e_clamp | NP'(1 << p));
      wr(A_TOG, 32'h100 | p);
      for (int t = 0; t <= TL; t++) begin
         if (t > 0) step();
         rd(A_TOG, v);
         chk("R2 start flag", {31'b0, v[8]}, {31'b0, (t < TL)});
         if (t == 1) chk("R2 toggle readback", v, 32'h100 | p);
         chk("R3 power", 32'(pwr_en), 32'((t >= TL) ? nxt_pwr : e_pwr));
         chk("R9 clamp", 32'(clamp), 32'((t >= TL) ? nxt_clamp : e_clamp));
      end
      e_pwr = nxt_pwr;
      e_clamp = nxt_clamp;
   endtask

   initial begin
      logic [31:0] v;
      logic [NP-1:0] mask;
      e_pwr = '0;
      e_clamp = ALL;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk("R1 pwr_en", 32'(pwr_en), 32'h0);
      chk("R1 clamp", 32'(clamp), 32'(ALL));
      chk("R1 err", {31'b0, clamp_err}, 32'h0);
      rd(A_TOG, v); chk("R1 toggle reg", v, 32'h0);
      rd(A_CMD, v); chk("R1 cmd reg", v, 32'h0);
      rd(A_CST, v); chk("R5 clamp status", v, 32'(ALL));

      // R4 ignored toggle writes
      wr(A_TOG, 32'h001);
      rd(A_TOG, v); chk("R4 no start bit", {31'b0, v[8]}, 32'h0);
      wr(A_TOG, 32'h107);
      rd(A_TOG, v); chk("R4 id out of range", {31'b0, v[8]}, 32'h0);
      repeat (TL + 1) step();
      chk("R4 power unchanged", 32'(pwr_en), 32'h0);

      // R2 sweep: power every partition on
      for (int p = 0; p < NP; p++) do_toggle(p);
      rd(A_PST, v); chk("R5 power status", v, 32'(e_pwr));

      // R7 ordered service of several releases
      mask = 6'h2D;
      wr(A_CMD, 32'(mask));
      for (int t = 0; t <= 4 * (CL + 1); t++) begin
         logic [NP-1:0] ec, ep;
         int rank;
         if (t > 0) step();
         ec = e_clamp; ep = '0; rank = 0;
         for (int i = 0; i < NP; i++) begin
            if (mask[i]) begin
               rank++;
               if (t >= rank * (CL + 1)) ec[i] = 1'b0;
               else ep[i] = 1'b1;
            end
         end
         chk("R7 clamp order", 32'(clamp), 32'(ec));
         rd(A_CMD, v); chk("R7 pending", v, 32'(ep));
      end
      e_clamp = e_clamp & ~mask;

      // R4 busy ignore + R9 reclamp: toggle 0 off, try toggle 4 while busy
      wr(A_TOG, 32'h100);
      wr(A_TOG, 32'h104);
      for (int t = 1; t <= TL; t++) begin
         if (t > 1) step();
         chk("R9 clamp timing", {31'b0, clamp[0]}, {31'b0, (t >= TL)});
      end
      rd(A_TOG, v); chk("R4 busy-write dropped", v, 32'h000);
      chk("R4 power after busy write", 32'(pwr_en), 32'h3E);
      e_pwr = 6'h3E; e_clamp = e_clamp | 6'h01;

      // R10 release coinciding with power-off: dropped, no error
      wr(A_TOG, 32'h104);
      repeat (TL - 1) step();
      wr(A_CMD, 32'h10);
      chk("R10 off: power", 32'(pwr_en), 32'h2E);
      chk("R10 off: clamp kept", {31'b0, clamp[4]}, 32'h1);
      chk("R10 off: no error", {31'b0, clamp_err}, 32'h0);
      rd(A_CMD, v); chk("R10 off: cmd cleared", v, 32'h0);
      repeat (CL + 2) step();
      chk("R9 clamp still set", {31'b0, clamp[4]}, 32'h1);
      e_pwr = 6'h2E;

      // R10 release coinciding with power-on: refused with error
      wr(A_TOG, 32'h104);
      repeat (TL - 1) step();
      wr(A_CMD, 32'h10);
      chk("R10 on: power", 32'(pwr_en), 32'h3E);
      chk("R10 on: error", {31'b0, clamp_err}, 32'h1);
      rd(A_CMD, v); chk("R10 on: cmd", v, 32'h0);
      repeat (CL + 2) step();
      chk("R10 on: clamp kept", {31'b0, clamp[4]}, 32'h1);
      e_pwr = 6'h3E;

      // R6 single release timing on partition 4
      wr(A_CMD, 32'h10);
      for (int t = 0; t <= CL + 1; t++) begin
         if (t > 0) step();
         chk("R6 clamp", {31'b0, clamp[4]}, {31'b0, (t < CL + 1)});
         rd(A_CMD, v); chk("R6 cmd bit", v, (t < CL + 1) ? 32'h10 : 32'h0);
      end
      e_clamp = e_clamp & ~6'h10;

      // R8 release on unpowered partition 0
      wr(A_CMD, 32'h01);
      rd(A_CMD, v); chk("R8 cmd not held", v, 32'h0);
      repeat (CL + 3) step();
      chk("R8 clamp kept", 32'(clamp), 32'(e_clamp));
      chk("R8 error sticky", {31'b0, clamp_err}, 32'h1);

      // R3 double toggle returns the state
      do_toggle(0);
      do_toggle(0);
      rd(A_PST, v); chk("R3 power status", v, 32'(e_pwr));
      rd(A_CST, v); chk("R5 clamp status", v, 32'(e_clamp));
      rd(12'h040, v); chk("R5 unmapped", v, 32'h0);

      // R1 reset clears the sticky error
      rst = 1'b1; step(); step(); rst = 1'b0;
      chk("R1 err after reset", {31'b0, clamp_err}, 32'h0);
      chk("R1 clamp after reset", 32'(clamp), 32'(ALL));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule